// File: doc/BRIEF.md
# 16-bit Carry-Chained Add/Subtract Unit with Flag Byte

This combinational unit combines a 16-bit accumulator with a 16-bit operand and an incoming carry. It either adds the two with the carry, or subtracts the operand and the carry from the accumulator. It returns the 16-bit result and a full 8-bit condition byte. The condition byte holds the sign, zero, half-carry, overflow, subtract and carry indications. It also carries two copies of result bits into the otherwise undocumented flag positions.

A separate mode input switches the unit to an 8-bit negate. In that mode the low byte of the accumulator is replaced by its two's complement, and the flags follow the byte-negate rules. The unit has no clock and no reset. The surrounding datapath registers its outputs and decides when to write them back.

Flag byte layout, bit 7 down to bit 0: S, Z, Y (copy), H, X (copy), P/V, N, C.

Top module: `carry_flag_alu16`

## Requirements
- R1: With neg_i=0 and sub_i=0, res_o equals (acc_i + opnd_i + cin_i) mod 2^16.
- R2: With neg_i=0 and sub_i=1, res_o equals (acc_i - opnd_i - cin_i) mod 2^16.
- R3: In 16-bit mode flags_o[0] (C) is set when the add overflows 16 bits, or when the subtract needs a borrow, meaning acc_i < opnd_i + cin_i.
- R4: In 16-bit mode flags_o[4] (H) is set when the low 12 bits, carry included, carry out of bit 11 on add, or need a borrow into bit 11 on subtract.
- R5: In 16-bit mode flags_o[2] (P/V) is set on signed two's-complement overflow of the 16-bit add or subtract, carry included.
- R6: In 16-bit mode flags_o[6] (Z) is set exactly when res_o is 0x0000.
- R7: In 16-bit mode flags_o[7], flags_o[5] and flags_o[3] equal res_o bits 15, 13 and 11.
- R8: In 16-bit mode flags_o[1] (N) equals sub_i.
- R9: With neg_i=1, res_o[7:0] equals (0 - acc_i[7:0]) mod 256, whatever the values of opnd_i, sub_i and cin_i.
- R10: With neg_i=1, N is set. H is set when acc_i[3:0] is nonzero, P/V when acc_i[7:0] is 0x80, and C when acc_i[7:0] is nonzero. Z is set when the 8-bit result is zero, and S, bit 5 and bit 3 copy result bits 7, 5 and 3.
- R11: With neg_i=1, res_o[15:8] equals acc_i[15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 16 | Accumulator pair operand |
| opnd_i | input | 16 | Register operand |
| cin_i | input | 1 | Incoming carry or borrow |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| neg_i | input | 1 | 1 selects 8-bit negate of acc_i[7:0] |
| res_o | output | 16 | Result |
| flags_o | output | 8 | Flag byte S,Z,Y,H,X,P/V,N,C (bit 7 to 0) |

## Verification
Assertions inside the design check several things whenever the inputs change. They check that Z agrees with the result and that N follows the selected operation. They check that overflow never appears on an add of opposite-sign operands. In negate mode they check the carry and overflow rules and the pass-through of the high byte. The exact arithmetic needs an independent model. This covers the 17-bit sum, the borrow, the bit-11 half carry and signed overflow near 0x7FFF/0x8000 with carry-in of both values. The bench's scoreboard shows this over corner and random operands.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_X  = 3;
  localparam int FLG_H  = 4;
  localparam int FLG_Y  = 5;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } flags_t;

  // Adds two 16-bit values and a carry, keeping the carry out as bit 16.
  function automatic logic [16:0] sum17(input logic [15:0] a, input logic [15:0] b, input logic ci);
    return {1'b0, a} + {1'b0, b} + {16'd0, ci};
  endfunction

  // Adds two 12-bit values and a carry, keeping the carry out as bit 12.
  function automatic logic [12:0] sum13(input logic [11:0] a, input logic [11:0] b, input logic ci);
    return {1'b0, a} + {1'b0, b} + {12'd0, ci};
  endfunction
endpackage

// File: rtl/wide_addsub.sv
module wide_addsub
  import alu16_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        ci_i,
  input  logic        sub_i,
  output logic [15:0] sum_o,
  output logic        carry_o,
  output logic        half_o,
  output logic        ovf_o
);
  logic [15:0] b_eff;
  logic        ci_eff;
  logic [16:0] full;
  logic [12:0] low;

  // Subtract is formed as a + ~b + ~ci, with the carries inverted into borrows.
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign ci_eff  = sub_i ? ~ci_i : ci_i;
  assign full    = sum17(a_i, b_eff, ci_eff);
  assign low     = sum13(a_i[11:0], b_eff[11:0], ci_eff);
  assign sum_o   = full[15:0];
  assign carry_o = full[16] ^ sub_i;
  assign half_o  = low[12] ^ sub_i;
  assign ovf_o   = (a_i[15] == b_eff[15]) && (full[15] != a_i[15]);
endmodule

// File: rtl/byte_negate.sv
module byte_negate (
  input  logic [7:0] v_i,
  output logic [7:0] neg_o,
  output logic       nz_o,
  output logic       lo_nz_o,
  output logic       minval_o
);
  assign neg_o    = 8'd0 - v_i;
  assign nz_o     = |v_i;
  assign lo_nz_o  = |v_i[3:0];
  assign minval_o = (v_i == 8'h80);
endmodule

// File: rtl/carry_flag_alu16.sv
module carry_flag_alu16
  import alu16_pkg::*;
(
  input  logic [15:0] acc_i,
  input  logic [15:0] opnd_i,
  input  logic        cin_i,
  input  logic        sub_i,
  input  logic        neg_i,
  output logic [15:0] res_o,
  output logic [7:0]  flags_o
);
  logic [15:0] wide_sum;
  logic        wide_carry, wide_half, wide_ovf;
  logic [7:0]  neg_byte;
  logic        neg_nz, neg_lo_nz, neg_min;
  flags_t      fl;

  wide_addsub u_wide (
    .a_i(acc_i), .b_i(opnd_i), .ci_i(cin_i), .sub_i(sub_i),
    .sum_o(wide_sum), .carry_o(wide_carry), .half_o(wide_half), .ovf_o(wide_ovf)
  );

  byte_negate u_neg (
    .v_i(acc_i[7:0]), .neg_o(neg_byte), .nz_o(neg_nz),
    .lo_nz_o(neg_lo_nz), .minval_o(neg_min)
  );

  always_comb begin
    if (neg_i) begin
      res_o = {acc_i[15:8], neg_byte};
      fl.s  = neg_byte[7];
      fl.z  = (neg_byte == 8'h00);
      fl.y  = neg_byte[5];
      fl.h  = neg_lo_nz;
      fl.x  = neg_byte[3];
      fl.pv = neg_min;
      fl.n  = 1'b1;
      fl.c  = neg_nz;
    end else begin
      res_o = wide_sum;
      fl.s  = wide_sum[15];
      fl.z  = (wide_sum == 16'h0000);
      fl.y  = wide_sum[13];
      fl.h  = wide_half;
      fl.x  = wide_sum[11];
      fl.pv = wide_ovf;
      fl.n  = sub_i;
      fl.c  = wide_carry;
    end
  end

  assign flags_o = fl;

  always_comb begin
    // R6
    zero_flag_chk: assert (neg_i || (flags_o[FLG_Z] == (res_o == 16'h0000)));
    // R8
    sub_flag_chk: assert (neg_i || (flags_o[FLG_N] == sub_i));
    // R5
    add_sign_ovf_chk: assert (neg_i || sub_i || (acc_i[15] == opnd_i[15]) || !flags_o[FLG_PV]);
    // R10
    neg_carry_chk: assert (!neg_i || (flags_o[FLG_C] == (acc_i[7:0] != 8'h00)));
    // R10
    neg_ovf_chk: assert (!neg_i || (flags_o[FLG_PV] == (acc_i[7:0] == 8'h80)));
    // R11
    neg_high_chk: assert (!neg_i || (res_o[15:8] == acc_i[15:8]));
  end
endmodule

// File: tb/tb_carry_flag_alu16.sv
module tb_carry_flag_alu16;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] acc, opnd, res;
  logic        cin, sub, neg;
  logic [7:0]  flags;

  carry_flag_alu16 dut (
    .acc_i(acc), .opnd_i(opnd), .cin_i(cin), .sub_i(sub), .neg_i(neg),
    .res_o(res), .flags_o(flags)
  );

  typedef struct {
    logic        negm;
    logic        subm;
    logic [15:0] res;
    logic [7:0]  fl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (acc=%h opnd=%h cin=%b sub=%b neg=%b)",
               tag, act, exp, acc, opnd, cin, sub, neg);
    end
  endtask

  // Driver: applies one stimulus per cycle and queues the model's prediction.
  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input logic s, input logic n);
    exp_t e;
    int   ua, ub, t, sa, sb, sr;
    logic [7:0] v, r8;
    @(posedge clk);
    #1;
    acc = a; opnd = b; cin = c; sub = s; neg = n;
    e.negm = n; e.subm = s;
    if (n) begin
      v  = a[7:0];
      r8 = 8'((256 - int'(v)) % 256);
      e.res = {a[15:8], r8};
      e.fl  = {r8[7], r8 == 8'h00, r8[5], v[3:0] != 4'h0, r8[3], v == 8'h80, 1'b1, v != 8'h00};
    end else begin
      ua = int'(a); ub = int'(b);
      sa = int'($signed(a)); sb = int'($signed(b));
      if (s) begin
        t  = ua - ub - int'(c);
        sr = sa - sb - int'(c);
        e.fl[0] = (ua < ub + int'(c));
        e.fl[4] = ((ua % 4096) < (ub % 4096) + int'(c));
      end else begin
        t  = ua + ub + int'(c);
        sr = sa + sb + int'(c);
        e.fl[0] = (t > 65535);
        e.fl[4] = ((ua % 4096) + (ub % 4096) + int'(c) > 4095);
      end
      e.res   = 16'((t + 65536) % 65536);
      e.fl[2] = (sr > 32767) || (sr < -32768);
      e.fl[6] = (e.res == 16'h0000);
      e.fl[7] = e.res[15];
      e.fl[5] = e.res[13];
      e.fl[3] = e.res[11];
      e.fl[1] = s;
    end
    q.push_back(e);
  endtask

  // Monitor: compares at the falling edge, well after the inputs settle.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.negm) begin
          chk("R9 negate byte", {8'h00, res[7:0]}, {8'h00, e.res[7:0]});
          chk("R11 high byte kept", {8'h00, res[15:8]}, {8'h00, e.res[15:8]});
          chk("R10 negate flags", {8'h00, flags}, {8'h00, e.fl});
        end else begin
          chk(e.subm ? "R2 difference" : "R1 sum", res, e.res);
          chk("R3 carry/borrow", {15'd0, flags[0]}, {15'd0, e.fl[0]});
          chk("R4 half carry", {15'd0, flags[4]}, {15'd0, e.fl[4]});
          chk("R5 overflow", {15'd0, flags[2]}, {15'd0, e.fl[2]});
          chk("R6 zero", {15'd0, flags[6]}, {15'd0, e.fl[6]});
          chk("R7 copied bits", {13'd0, flags[7], flags[5], flags[3]},
              {13'd0, e.fl[7], e.fl[5], e.fl[3]});
          chk("R8 subtract flag", {15'd0, flags[1]}, {15'd0, e.fl[1]});
        end
      end
    end
  end

  initial begin
    logic [15:0] corners [4];
    logic [7:0]  ncorn [6];
    corners[0] = 16'h0000; corners[1] = 16'h7FFF;
    corners[2] = 16'h8000; corners[3] = 16'hFFFF;
    ncorn[0] = 8'h00; ncorn[1] = 8'h01; ncorn[2] = 8'h80;
    ncorn[3] = 8'hFF; ncorn[4] = 8'h10; ncorn[5] = 8'h7F;
    acc = '0; opnd = '0; cin = 0; sub = 0; neg = 0;
    // Idle inputs: 0 + 0 must give a zero result with Z set (R6).
    drive(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            drive(corners[i], corners[j], c[0], s[0], 1'b0);
    // Half-carry boundary at bit 11 (R4).
    drive(16'h0FFF, 16'h0000, 1'b1, 1'b0, 1'b0);
    drive(16'h1000, 16'h0000, 1'b1, 1'b1, 1'b0);
    drive(16'h1000, 16'h0FFF, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 300; k++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    // Negate: opnd, cin and sub must not matter (R9).
    for (int i = 0; i < 6; i++)
      drive({8'hA5, ncorn[i]}, 16'hFFFF, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 60; k++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b1);
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule